// File: doc/BRIEF.md
# Data Translation Fault Exception Entry

This block is the entry sequencer that a 32-bit core invokes when a data-side access (load, store or cache-management operation) cannot complete address translation. Bit numbering throughout is big-endian: bit 0 is the most significant bit of a word. The block samples three fault strobes on each clock edge: translation miss, protection denial, and write to a page whose change bit is clear. It also samples a load/store flag, the address of the faulting instruction, the data effective address and the current machine state word.

On the edge where any fault strobe is high, the block loads new values for both save/restore registers, the machine state register, the fault status register and the data address register. It raises a one-cycle write enable for each of them, together with a redirect strobe and the target address. The surrounding core commits all of these values as one atomic group. On edges with no fault, every write enable is low and the outputs hold their values.

Top module: `dxlat_fault_entry`

## Requirements
- R1: On a fault edge, the save/restore register 0 output takes the faulting instruction address.
- R2: On a fault, save/restore register 1 takes every bit of the machine state word at the same position, except bits 1 to 4 and bits 10 to 15, which are written as zero.
- R3: Save/restore register 1 bit 30 always equals the sampled machine-state recoverable bit (bit 30), so fault entry itself never clears it.
- R4: The new machine state keeps bit 25 (vector prefix) and bit 19 (machine-check enable). Bit 31 (little-endian) takes the value of bit 15 (interrupt little-endian). Every other bit is zero.
- R5: Fault status bit 1 is set exactly when the translation-miss strobe is high.
- R6: Fault status bit 4 is set when the protection strobe or the change-bit strobe is high and the miss strobe is low. A miss suppresses bit 4.
- R7: Fault status bit 6 is 1 for a store and 0 for a load. Bits 0, 2, 3, 5 and 7 to 31 are zero.
- R8: On a fault, the data address register output takes the data effective address.
- R9: The redirect target is 0x00001400 when machine-state bit 25 is 0, and 0xFFF01400 when it is 1.
- R10: All five write enables and the redirect strobe are high for exactly the cycle after the fault edge.
- R11: With no fault strobe active, all write enables and the redirect strobe are low, and every value output holds.
- R12: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_miss_i | input | 1 | No translation found |
| flt_prot_i | input | 1 | Protection denial |
| flt_chg_i | input | 1 | Write to page with change bit clear |
| is_store_i | input | 1 | 1 = store, 0 = load |
| insn_ea_i | input | 32 | Faulting instruction address |
| data_ea_i | input | 32 | Faulting data effective address |
| msr_i | input | 32 | Current machine state word |
| srr0_o | output | 32 | New save/restore register 0 |
| srr0_we_o | output | 1 | Write enable for srr0_o |
| srr1_o | output | 32 | New save/restore register 1 |
| srr1_we_o | output | 1 | Write enable for srr1_o |
| msr_o | output | 32 | New machine state |
| msr_we_o | output | 1 | Write enable for msr_o |
| dsisr_o | output | 32 | New fault status |
| dsisr_we_o | output | 1 | Write enable for dsisr_o |
| dar_o | output | 32 | New data address register |
| dar_we_o | output | 1 | Write enable for dar_o |
| redirect_o | output | 1 | Redirect strobe |
| target_o | output | 32 | Redirect address |

## Verification
The assertions check the following on every cycle: the enables rise together one edge after a fault, and outputs hold when there is no fault. They also check that the zeroed save-state fields and the cleared machine-state bits stay zero, that the recoverable bit follows its source, that a miss wins over a protection fault, and that the target is one of the two legal vectors. Only the bench scenarios show the full bit-exact values against an independent model. These include the change-bit fault reported as a protection fault, combined miss-and-protection strobes, the prefix bit moving the vector, and register contents held unchanged across idle stretches.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  localparam int unsigned XLEN = 32;

  // Convert a big-endian bit number (0 = MSB) to a vector index.
  function automatic int unsigned be_idx(input int unsigned b);
    return XLEN - 1 - b;
  endfunction
endpackage

// File: rtl/dtf_save_build.sv
module dtf_save_build
  import dtf_pkg::*;
#(
  parameter int unsigned ZA_LO   = 1,
  parameter int unsigned ZA_HI   = 4,
  parameter int unsigned ZB_LO   = 10,
  parameter int unsigned ZB_HI   = 15,
  parameter int unsigned IP_BIT  = 25,
  parameter int unsigned ME_BIT  = 19,
  parameter int unsigned ILE_BIT = 15,
  parameter int unsigned LE_BIT  = 31
) (
  input  logic [XLEN-1:0] state_in,
  output logic [XLEN-1:0] saved_state,
  output logic [XLEN-1:0] entry_state
);
  // Saved state: positional copy with two forced-zero fields.
  for (genvar b = 0; b < XLEN; b++) begin : g_save
    localparam bit ZERO_FIELD = ((b >= ZA_LO) && (b <= ZA_HI)) ||
                                ((b >= ZB_LO) && (b <= ZB_HI));
    if (ZERO_FIELD) begin : g_z
      assign saved_state[be_idx(b)] = 1'b0;
    end else begin : g_c
      assign saved_state[be_idx(b)] = state_in[be_idx(b)];
    end
  end

  // Entry state: everything cleared except the preserved / remapped bits.
  always_comb begin
    entry_state                 = '0;
    entry_state[be_idx(IP_BIT)] = state_in[be_idx(IP_BIT)];
    entry_state[be_idx(ME_BIT)] = state_in[be_idx(ME_BIT)];
    entry_state[be_idx(LE_BIT)] = state_in[be_idx(ILE_BIT)];
  end
endmodule

// File: rtl/dtf_status_enc.sv
module dtf_status_enc
  import dtf_pkg::*;
#(
  parameter int unsigned MISS_BIT = 1,
  parameter int unsigned PROT_BIT = 4,
  parameter int unsigned ST_BIT   = 6
) (
  input  logic            miss,
  input  logic            prot,
  input  logic            chg,
  input  logic            store,
  output logic [XLEN-1:0] status
);
  always_comb begin
    status                   = '0;
    status[be_idx(MISS_BIT)] = miss;
    status[be_idx(PROT_BIT)] = (prot | chg) & ~miss;
    status[be_idx(ST_BIT)]   = store;
  end
endmodule

// File: rtl/dtf_vector_sel.sv
module dtf_vector_sel
  import dtf_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_1400,
  parameter logic [XLEN-1:0] BASE_LO    = 32'h0000_0000,
  parameter logic [XLEN-1:0] BASE_HI    = 32'hFFF0_0000
) (
  input  logic            prefix,
  output logic [XLEN-1:0] target
);
  assign target = (prefix ? BASE_HI : BASE_LO) | VEC_OFFSET;
endmodule

// File: rtl/dxlat_fault_entry.sv
module dxlat_fault_entry
  import dtf_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_1400,
  parameter logic [XLEN-1:0] BASE_LO    = 32'h0000_0000,
  parameter logic [XLEN-1:0] BASE_HI    = 32'hFFF0_0000,
  parameter int unsigned     IP_BIT     = 25,
  parameter int unsigned     ME_BIT     = 19,
  parameter int unsigned     ILE_BIT    = 15,
  parameter int unsigned     LE_BIT     = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flt_miss_i,
  input  logic            flt_prot_i,
  input  logic            flt_chg_i,
  input  logic            is_store_i,
  input  logic [XLEN-1:0] insn_ea_i,
  input  logic [XLEN-1:0] data_ea_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] srr0_o,
  output logic            srr0_we_o,
  output logic [XLEN-1:0] srr1_o,
  output logic            srr1_we_o,
  output logic [XLEN-1:0] msr_o,
  output logic            msr_we_o,
  output logic [XLEN-1:0] dsisr_o,
  output logic            dsisr_we_o,
  output logic [XLEN-1:0] dar_o,
  output logic            dar_we_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o
);
  logic            fault_any;
  logic [XLEN-1:0] saved_nx, entry_nx, status_nx, target_nx;

  assign fault_any = flt_miss_i | flt_prot_i | flt_chg_i;

  dtf_save_build #(
    .IP_BIT(IP_BIT), .ME_BIT(ME_BIT), .ILE_BIT(ILE_BIT), .LE_BIT(LE_BIT)
  ) u_save (
    .state_in   (msr_i),
    .saved_state(saved_nx),
    .entry_state(entry_nx)
  );

  dtf_status_enc u_status (
    .miss  (flt_miss_i),
    .prot  (flt_prot_i),
    .chg   (flt_chg_i),
    .store (is_store_i),
    .status(status_nx)
  );

  dtf_vector_sel #(
    .VEC_OFFSET(VEC_OFFSET), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_vec (
    .prefix(msr_i[be_idx(IP_BIT)]),
    .target(target_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      srr0_o     <= '0;
      srr1_o     <= '0;
      msr_o      <= '0;
      dsisr_o    <= '0;
      dar_o      <= '0;
      target_o   <= '0;
      srr0_we_o  <= 1'b0;
      srr1_we_o  <= 1'b0;
      msr_we_o   <= 1'b0;
      dsisr_we_o <= 1'b0;
      dar_we_o   <= 1'b0;
      redirect_o <= 1'b0;
    end else begin
      srr0_we_o  <= fault_any;
      srr1_we_o  <= fault_any;
      msr_we_o   <= fault_any;
      dsisr_we_o <= fault_any;
      dar_we_o   <= fault_any;
      redirect_o <= fault_any;
      if (fault_any) begin
        srr0_o   <= insn_ea_i;
        srr1_o   <= saved_nx;
        msr_o    <= entry_nx;
        dsisr_o  <= status_nx;
        dar_o    <= data_ea_i;
        target_o <= target_nx;
      end
    end
  end
endmodule

// File: rtl/dtf_fault_entry_chk.sv
module dtf_fault_entry_chk
  import dtf_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_1400,
  parameter logic [XLEN-1:0] BASE_LO    = 32'h0000_0000,
  parameter logic [XLEN-1:0] BASE_HI    = 32'hFFF0_0000
) (
  input logic            clk,
  input logic            rst,
  input logic            flt_miss_i,
  input logic            flt_prot_i,
  input logic            flt_chg_i,
  input logic            is_store_i,
  input logic [XLEN-1:0] insn_ea_i,
  input logic [XLEN-1:0] data_ea_i,
  input logic [XLEN-1:0] msr_i,
  input logic [XLEN-1:0] srr0_o,
  input logic            srr0_we_o,
  input logic [XLEN-1:0] srr1_o,
  input logic            srr1_we_o,
  input logic [XLEN-1:0] msr_o,
  input logic            msr_we_o,
  input logic [XLEN-1:0] dsisr_o,
  input logic            dsisr_we_o,
  input logic [XLEN-1:0] dar_o,
  input logic            dar_we_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o
);
  logic flt;
  assign flt = flt_miss_i | flt_prot_i | flt_chg_i;

  // Bits that may be nonzero in the entry state: 19, 25, 31 (big-endian).
  localparam logic [XLEN-1:0] MSR_KEEP = (XLEN'(1) << be_idx(19)) |
                                         (XLEN'(1) << be_idx(25)) |
                                         (XLEN'(1) << be_idx(31));
  // Bits that may be nonzero in the status word: 1, 4, 6.
  localparam logic [XLEN-1:0] STS_KEEP = (XLEN'(1) << be_idx(1)) |
                                         (XLEN'(1) << be_idx(4)) |
                                         (XLEN'(1) << be_idx(6));

  a_r10_all_enables: assert property (@(posedge clk) disable iff (rst)
    flt |=> (srr0_we_o && srr1_we_o && msr_we_o && dsisr_we_o && dar_we_o && redirect_o));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !flt |=> (!srr0_we_o && !srr1_we_o && !msr_we_o && !dsisr_we_o && !dar_we_o &&
              !redirect_o && $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) &&
              $stable(dsisr_o) && $stable(dar_o) && $stable(target_o)));

  a_r1_srr0_value: assert property (@(posedge clk) disable iff (rst)
    flt |=> (srr0_o == $past(insn_ea_i)));

  a_r8_dar_value: assert property (@(posedge clk) disable iff (rst)
    flt |=> (dar_o == $past(data_ea_i)));

  a_r2_zero_fields: assert property (@(posedge clk) disable iff (rst)
    srr1_we_o |-> (srr1_o[XLEN-2 -: 4] == 4'h0 && srr1_o[XLEN-11 -: 6] == 6'h0));

  a_r3_ri_follows: assert property (@(posedge clk) disable iff (rst)
    flt |=> (srr1_o[be_idx(30)] == $past(msr_i[be_idx(30)])));

  a_r4_msr_clear: assert property (@(posedge clk) disable iff (rst)
    msr_we_o |-> ((msr_o & ~MSR_KEEP) == '0));

  a_r5_miss_bit: assert property (@(posedge clk) disable iff (rst)
    flt |=> (dsisr_o[be_idx(1)] == $past(flt_miss_i)));

  a_r6_miss_priority: assert property (@(posedge clk) disable iff (rst)
    flt_miss_i |=> !dsisr_o[be_idx(4)]);

  a_r7_store_bit: assert property (@(posedge clk) disable iff (rst)
    flt |=> (dsisr_o[be_idx(6)] == $past(is_store_i) && (dsisr_o & ~STS_KEEP) == '0));

  a_r9_vector: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (target_o == (BASE_LO | VEC_OFFSET) || target_o == (BASE_HI | VEC_OFFSET)));
endmodule

bind dxlat_fault_entry dtf_fault_entry_chk #(
  .VEC_OFFSET(VEC_OFFSET), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) u_chk (
  .clk(clk), .rst(rst), .flt_miss_i(flt_miss_i), .flt_prot_i(flt_prot_i),
  .flt_chg_i(flt_chg_i), .is_store_i(is_store_i), .insn_ea_i(insn_ea_i),
  .data_ea_i(data_ea_i), .msr_i(msr_i), .srr0_o(srr0_o), .srr0_we_o(srr0_we_o),
  .srr1_o(srr1_o), .srr1_we_o(srr1_we_o), .msr_o(msr_o), .msr_we_o(msr_we_o),
  .dsisr_o(dsisr_o), .dsisr_we_o(dsisr_we_o), .dar_o(dar_o), .dar_we_o(dar_we_o),
  .redirect_o(redirect_o), .target_o(target_o)
);

// File: tb/dxlat_fault_entry_bench.sv
module dxlat_fault_entry_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss = 1'b0, prot = 1'b0, chg = 1'b0, st = 1'b0;
  logic [31:0] iea = '0, dea = '0, msr = '0;
  logic [31:0] srr0, srr1, msro, dsisr, dar, tgt;
  logic        srr0_we, srr1_we, msr_we, dsisr_we, dar_we, redir;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Expected output state (reference model).
  logic [31:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_dsisr = '0, e_dar = '0, e_tgt = '0;
  logic        e_we = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dxlat_fault_entry u_dxlat_fault_entry (
    .clk(clk), .rst(rst), .flt_miss_i(miss), .flt_prot_i(prot), .flt_chg_i(chg),
    .is_store_i(st), .insn_ea_i(iea), .data_ea_i(dea), .msr_i(msr),
    .srr0_o(srr0), .srr0_we_o(srr0_we), .srr1_o(srr1), .srr1_we_o(srr1_we),
    .msr_o(msro), .msr_we_o(msr_we), .dsisr_o(dsisr), .dsisr_we_o(dsisr_we),
    .dar_o(dar), .dar_we_o(dar_we), .redirect_o(redir), .target_o(tgt)
  );

  function automatic logic getb(input logic [31:0] w, input int b);
    return w[31-b];
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: what the next edge should produce from the current inputs.
  task automatic model_step;
    logic [31:0] s1, m, d;
    if (rst) begin
      e_srr0 = '0; e_srr1 = '0; e_msr = '0; e_dsisr = '0; e_dar = '0; e_tgt = '0; e_we = 0;
      return;
    end
    e_we = miss | prot | chg;
    if (!e_we) return;  // R11: values hold
    s1 = '0;
    for (int b = 0; b < 32; b++)
      if (!((b >= 1 && b <= 4) || (b >= 10 && b <= 15))) s1[31-b] = getb(msr, b);
    m = '0;
    m[31-25] = getb(msr, 25);
    m[31-19] = getb(msr, 19);
    m[31-31] = getb(msr, 15);
    d = '0;
    d[31-1] = miss;
    d[31-4] = !miss && (prot || chg);
    d[31-6] = st;
    e_srr0 = iea; e_srr1 = s1; e_msr = m; e_dsisr = d; e_dar = dea;
    e_tgt  = getb(msr, 25) ? 32'hFFF0_1400 : 32'h0000_1400;
  endtask

  task automatic check_all;
    cmp("R1 srr0", srr0, e_srr0);
    cmp("R2 srr1", srr1, e_srr1);
    cmp("R3 srr1.ri", {31'b0, srr1[1]}, {31'b0, e_srr1[1]});
    cmp("R4 msr", msro, e_msr);
    cmp("R5 dsisr.miss", {31'b0, dsisr[30]}, {31'b0, e_dsisr[30]});
    cmp("R6 dsisr.prot", {31'b0, dsisr[27]}, {31'b0, e_dsisr[27]});
    cmp("R7 dsisr", dsisr, e_dsisr);
    cmp("R8 dar", dar, e_dar);
    cmp("R9 target", tgt, e_tgt);
    cmp(e_we ? "R10 enables" : "R11 enables",
        {26'b0, srr0_we, srr1_we, msr_we, dsisr_we, dar_we, redir}, {26'b0, {6{e_we}}});
  endtask

  // Apply one stimulus at a negedge, then check after the following edge.
  task automatic step(input logic mi, input logic pr, input logic ch, input logic s,
                      input logic [31:0] ie, input logic [31:0] de, input logic [31:0] ms);
    miss = mi; prot = pr; chg = ch; st = s; iea = ie; dea = de; msr = ms;
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12: reset clears outputs
    rst = 1'b1; miss = 1'b1; msr = 32'hFFFF_FFFF; iea = 32'h1234_5678;
    model_step();
    repeat (3) @(negedge clk);
    check_all();
    miss = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R5, R1, R8: miss on a load, prefix 0
    step(1, 0, 0, 0, 32'h0000_2000, 32'hDEAD_BEE0, 32'h0000_0000);
    // R11: idle holds
    step(0, 0, 0, 1, 32'h1111_1111, 32'h2222_2222, 32'hFFFF_FFFF);
    // R6, R7, R9: protection fault on store, prefix 1, all state bits set
    step(0, 1, 0, 1, 32'h0000_3004, 32'h8000_0010, 32'hFFFF_FFFF);
    // R6: change-bit fault reports as protection
    step(0, 0, 1, 1, 32'h0000_3008, 32'h8000_0020, 32'h0001_0040);
    // R6: miss priority over protection
    step(1, 1, 1, 0, 32'h0000_300C, 32'h8000_0030, 32'h0000_4000);
    // R3: recoverable bit zero then one
    step(0, 1, 0, 0, 32'h0000_3010, 32'h0, 32'hFFFF_FFFD);
    step(0, 1, 0, 0, 32'h0000_3014, 32'h0, 32'h0000_0002);
    // R4: interrupt little-endian to little-endian
    step(0, 0, 1, 0, 32'h0000_3018, 32'h4, 32'h0001_1040);
    // R11: several idle cycles hold the last values
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 32'hAAAA_0000 + k, 32'h5555_0000, 32'h0);
    // Back-to-back faults
    step(1, 0, 0, 1, 32'h0000_4000, 32'h0000_0100, 32'h0000_0040);
    step(0, 1, 0, 0, 32'h0000_4004, 32'h0000_0200, 32'h0000_0000);

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0] & r[3], r[1] & r[3], r[2] & r[3], 1'($urandom),
           $urandom, $urandom, $urandom);
    end

    // R12: reset in the middle clears again
    rst = 1'b1;
    step(1, 1, 0, 1, 32'h9, 32'h9, 32'hFFFF_FFFF);
    rst = 1'b0;
    step(0, 0, 0, 0, 32'h0, 32'h0, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule